// File: doc/BRIEF.md
# External Edge Interrupt Controller

This block watches twenty-four event lines and turns selected transitions on them into latched pending flags, level interrupt requests and single-cycle event pulses. Sixteen of the lines are picked from general-purpose input ports: each of these lines has a 4-bit source field that chooses which port feeds it, and line i always takes pin i of the chosen port. The remaining eight lines come straight from internal wake-up and alarm sources that are already synchronous to the block clock.

Each line can be armed for rising edges, falling edges or both. A qualifying edge, or a software trigger, sets the line's pending flag. The flag stays set until software writes a one to it. An interrupt mask gates pending flags onto the interrupt outputs. Lines 0 to 4 and the internal lines each get their own output. Lines 5 to 9 share one output, and lines 10 to 15 share another. A separate event mask turns each trigger into a one-clock pulse. Software reaches everything through a small word-addressed register bus. Reads are combinational and writes take effect at the clock edge.

Top module: `exti_ctrl`

## Requirements
- R1: After reset every register reads zero, every source field selects port 0, and `irq_out` and `evt_out` are zero.
- R2: Byte offsets are: interrupt mask 0x00, event mask 0x04, rising select 0x08, falling select 0x0C, software trigger 0x10, pending 0x14, source fields of lines 0-7 at 0x18, source fields of lines 8-15 at 0x1C. Line i has its field in bits 4*(i%8)+3 : 4*(i%8). The six line registers use bits 23:0 (bit n is line n) and read bits 31:24 as zero. The software-trigger register always reads zero.
- R3: A rising edge on a line with its rising select set sets its pending bit. An input change applied before clock edge k is sampled at edge k, and the pending bit is set at edge k+1. A line with its rising select clear ignores rising edges.
- R4: A falling edge sets the pending bit only when the falling select is set. With both selects set, each edge direction sets the pending bit.
- R5: Writing 1 to a software-trigger bit sets the matching pending bit.
- R6: Writing 1 to a pending bit clears it. Writing 0 leaves it unchanged.
- R7: If a trigger and a clear of the same bit fall in the same cycle, the pending bit stays set.
- R8: The `irq_out` bits map as follows. Bits 4:0 follow lines 4:0. Bit 5 is the OR of lines 5-9. Bit 6 is the OR of lines 10-15. Bits 14:7 follow lines 23:16. A line counts only when it is pending and its interrupt-mask bit is 1.
- R9: The `evt_out[n]` bit is high for exactly the one cycle after line n triggers (an edge or a software write), and only if its event-mask bit was 1 in that trigger cycle.
- R10: A source field value k from 0 to 10 routes port k pin i to line i. Values 11 to 15 feed a constant 0 to the line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| port_pins | input | 176 | Port k pin i at bit 16*k+i, eleven ports |
| int_src | input | 8 | Internal sources for lines 16-23 |
| irq_out | output | 15 | Grouped interrupt requests |
| evt_out | output | 24 | One-cycle event pulses, one per line |

## Verification
The bench aims at timing and priority corners. The first is the two-edge latency from a pin change to its pending bit. A design with one sample register too few or too many would set the flag a cycle early or late. The second is a clear write that lands in the same cycle as a fresh edge. A design where clear wins would lose that interrupt. The bench also checks that a write of zeros to the pending register changes nothing, that disarmed edge directions are ignored, and that source fields of 11 or more feed a constant. A design that clamped or wrapped the field would let a real pin through. A cycle-by-cycle model confirms that the shared outputs OR exactly their own lines and that event pulses never last two cycles from a single trigger.

// File: rtl/exti_pkg.sv
package exti_pkg;

    // register word index = byte address / 4
    typedef enum logic [2:0] {
        REG_IMASK = 3'd0,
        REG_EMASK = 3'd1,
        REG_RISE  = 3'd2,
        REG_FALL  = 3'd3,
        REG_SWTRG = 3'd4,
        REG_PEND  = 3'd5,
        REG_PSEL0 = 3'd6,
        REG_PSEL1 = 3'd7
    } reg_idx_e;

    // interrupt grouping of the pin lines
    localparam int SOLO_LINES   = 5;  // lines 0..4 own one output each
    localparam int GROUP_A_LAST = 9;  // lines 5..9 share one output

endpackage

// File: rtl/exti_port_mux.sv
module exti_port_mux #(
    parameter int N_PORTS    = 11,
    parameter int GPIO_LINES = 16,
    parameter int SEL_W      = 4
) (
    input  logic [N_PORTS*GPIO_LINES-1:0] port_pins,
    input  logic [GPIO_LINES*SEL_W-1:0]   psel,
    output logic [GPIO_LINES-1:0]         line_in
);

    for (genvar i = 0; i < GPIO_LINES; i++) begin : g_line
        logic [SEL_W-1:0] sel;
        assign sel = psel[i*SEL_W +: SEL_W];
        always_comb begin
            line_in[i] = 1'b0;
            for (int k = 0; k < N_PORTS; k++) begin
                if (sel == SEL_W'(k)) line_in[i] = port_pins[k*GPIO_LINES + i];
            end
        end
    end

endmodule

// File: rtl/exti_line_core.sv
module exti_line_core #(
    parameter int N_LINES = 24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] raw_in,
    input  logic [N_LINES-1:0] rise_en,
    input  logic [N_LINES-1:0] fall_en,
    input  logic [N_LINES-1:0] emask,
    input  logic [N_LINES-1:0] sw_set,
    input  logic [N_LINES-1:0] clr,
    output logic [N_LINES-1:0] pend,
    output logic [N_LINES-1:0] evt
);

    logic [N_LINES-1:0] samp_q, prev_q, pend_q, evt_q, trig;

    always_comb begin
        trig = (samp_q & ~prev_q & rise_en) | (~samp_q & prev_q & fall_en) | sw_set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            samp_q <= '0;
            prev_q <= '0;
            pend_q <= '0;
            evt_q  <= '0;
        end else begin
            samp_q <= raw_in;
            prev_q <= samp_q;
            pend_q <= (pend_q & ~clr) | trig;
            evt_q  <= trig & emask;
        end
    end

    assign pend = pend_q;
    assign evt  = evt_q;

    // R6
    pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|clr) |=> ((pend_q & $past(clr & ~trig)) == '0));

    // R7
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|trig) |=> ((pend_q & $past(trig)) == $past(trig)));

    // R3
    no_spurious_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|pend_q) |-> ((pend_q & ~$past(pend_q) & ~$past(trig)) == '0));

    // R9
    evt_implies_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((evt_q & ~pend_q) == '0));

endmodule

// File: rtl/exti_regs.sv
module exti_regs
    import exti_pkg::*;
#(
    parameter int N_LINES    = 24,
    parameter int GPIO_LINES = 16,
    parameter int SEL_W      = 4,
    parameter int DW         = 32,
    parameter int AW         = 5
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        bus_en,
    input  logic                        bus_we,
    input  logic [AW-1:0]               bus_addr,
    input  logic [DW-1:0]               bus_wdata,
    output logic [DW-1:0]               bus_rdata,
    input  logic [N_LINES-1:0]          pend,
    output logic [N_LINES-1:0]          imask,
    output logic [N_LINES-1:0]          emask,
    output logic [N_LINES-1:0]          rise_en,
    output logic [N_LINES-1:0]          fall_en,
    output logic [GPIO_LINES*SEL_W-1:0] psel,
    output logic [N_LINES-1:0]          sw_set,
    output logic [N_LINES-1:0]          clr
);

    localparam int PSEL_W = GPIO_LINES * SEL_W;

    reg_idx_e idx;
    logic     wr;
    logic     unused_lsb;

    assign idx        = reg_idx_e'(bus_addr[AW-1:2]);
    assign wr         = bus_en & bus_we;
    assign unused_lsb = ^bus_addr[1:0];

    assign sw_set = (wr && idx == REG_SWTRG) ? bus_wdata[N_LINES-1:0] : '0;
    assign clr    = (wr && idx == REG_PEND)  ? bus_wdata[N_LINES-1:0] : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            imask   <= '0;
            emask   <= '0;
            rise_en <= '0;
            fall_en <= '0;
            psel    <= '0;
        end else if (wr) begin
            case (idx)
                REG_IMASK: imask   <= bus_wdata[N_LINES-1:0];
                REG_EMASK: emask   <= bus_wdata[N_LINES-1:0];
                REG_RISE:  rise_en <= bus_wdata[N_LINES-1:0];
                REG_FALL:  fall_en <= bus_wdata[N_LINES-1:0];
                REG_PSEL0: psel[DW-1:0]      <= bus_wdata;
                REG_PSEL1: psel[PSEL_W-1:DW] <= bus_wdata[PSEL_W-DW-1:0];
                default:   ;
            endcase
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (idx)
            REG_IMASK: bus_rdata[N_LINES-1:0] = imask;
            REG_EMASK: bus_rdata[N_LINES-1:0] = emask;
            REG_RISE:  bus_rdata[N_LINES-1:0] = rise_en;
            REG_FALL:  bus_rdata[N_LINES-1:0] = fall_en;
            REG_PEND:  bus_rdata[N_LINES-1:0] = pend;
            REG_PSEL0: bus_rdata = psel[DW-1:0];
            REG_PSEL1: bus_rdata[PSEL_W-DW-1:0] = psel[PSEL_W-1:DW];
            default:   bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/exti_ctrl.sv
module exti_ctrl
    import exti_pkg::*;
#(
    parameter int N_PORTS    = 11,
    parameter int GPIO_LINES = 16,
    parameter int INT_LINES  = 8,
    parameter int SEL_W      = 4,
    parameter int DW         = 32,
    parameter int AW         = 5,
    localparam int N_LINES   = GPIO_LINES + INT_LINES,
    localparam int IRQ_W     = SOLO_LINES + 2 + INT_LINES
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          bus_en,
    input  logic                          bus_we,
    input  logic [AW-1:0]                 bus_addr,
    input  logic [DW-1:0]                 bus_wdata,
    output logic [DW-1:0]                 bus_rdata,
    input  logic [N_PORTS*GPIO_LINES-1:0] port_pins,
    input  logic [INT_LINES-1:0]          int_src,
    output logic [IRQ_W-1:0]              irq_out,
    output logic [N_LINES-1:0]            evt_out
);

    logic [N_LINES-1:0]          imask, emask, rise_en, fall_en, sw_set, clr, pend;
    logic [GPIO_LINES*SEL_W-1:0] psel;
    logic [GPIO_LINES-1:0]       gpio_line;
    logic [N_LINES-1:0]          active;

    exti_regs #(
        .N_LINES(N_LINES), .GPIO_LINES(GPIO_LINES), .SEL_W(SEL_W), .DW(DW), .AW(AW)
    ) i_regs (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pend(pend), .imask(imask), .emask(emask), .rise_en(rise_en),
        .fall_en(fall_en), .psel(psel), .sw_set(sw_set), .clr(clr)
    );

    exti_port_mux #(
        .N_PORTS(N_PORTS), .GPIO_LINES(GPIO_LINES), .SEL_W(SEL_W)
    ) i_mux (
        .port_pins(port_pins), .psel(psel), .line_in(gpio_line)
    );

    exti_line_core #(.N_LINES(N_LINES)) i_core (
        .clk(clk), .rst_n(rst_n), .raw_in({int_src, gpio_line}),
        .rise_en(rise_en), .fall_en(fall_en), .emask(emask),
        .sw_set(sw_set), .clr(clr), .pend(pend), .evt(evt_out)
    );

    assign active = pend & imask;

    for (genvar j = 0; j < SOLO_LINES; j++) begin : g_solo
        assign irq_out[j] = active[j];
    end
    assign irq_out[SOLO_LINES]     = |active[GROUP_A_LAST:SOLO_LINES];
    assign irq_out[SOLO_LINES + 1] = |active[GPIO_LINES-1:GROUP_A_LAST+1];
    for (genvar k = 0; k < INT_LINES; k++) begin : g_int
        assign irq_out[SOLO_LINES + 2 + k] = active[GPIO_LINES + k];
    end

    // R9
    evt_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_out) |-> ((evt_out & ~$past(emask)) == '0));

    // R8
    irq_needs_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|irq_out[SOLO_LINES-1:0]) |-> ((irq_out[SOLO_LINES-1:0] & ~pend[SOLO_LINES-1:0]) == '0));

endmodule

// File: tb/test_exti_ctrl.sv
module test_exti_ctrl;

    localparam int CLK_P = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_en = 1'b0, bus_we = 1'b0;
    logic [4:0]   bus_addr = '0;
    logic [31:0]  bus_wdata = '0;
    logic [31:0]  bus_rdata;
    logic [175:0] port_pins = '0;
    logic [7:0]   int_src = '0;
    logic [14:0]  irq_out;
    logic [23:0]  evt_out;

    int checks = 0, bad = 0;
    bit done = 0;

    always #(CLK_P/2) clk = ~clk;

    exti_ctrl i_exti_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .port_pins(port_pins), .int_src(int_src), .irq_out(irq_out), .evt_out(evt_out)
    );

    // ---------------- behavioural reference model ----------------
    bit [23:0] m_imask, m_emask, m_rise, m_fall, m_pend, m_evt, m_now, m_old;
    int        m_sel [16];

    function automatic bit pin_of(int line);
        if (line >= 16) return int_src[line-16];
        if (m_sel[line] > 10) return 1'b0;
        return port_pins[m_sel[line]*16 + line];
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_imask = 0; m_emask = 0; m_rise = 0; m_fall = 0;
            m_pend = 0; m_evt = 0; m_now = 0; m_old = 0;
            for (int i = 0; i < 16; i++) m_sel[i] = 0;
        end else begin
            bit [23:0] t, c, nxt;
            t = 0; c = 0;
            for (int i = 0; i < 24; i++) begin
                if (m_rise[i] && m_now[i] && !m_old[i]) t[i] = 1;
                if (m_fall[i] && !m_now[i] && m_old[i]) t[i] = 1;
            end
            if (bus_en && bus_we && bus_addr == 5'h10) t = t | bus_wdata[23:0];
            if (bus_en && bus_we && bus_addr == 5'h14) c = bus_wdata[23:0];
            for (int i = 0; i < 24; i++) nxt[i] = pin_of(i);
            m_pend = (m_pend & ~c) | t;
            m_evt  = t & m_emask;
            m_old  = m_now;
            m_now  = nxt;
            if (bus_en && bus_we) begin
                case (bus_addr)
                    5'h00: m_imask = bus_wdata[23:0];
                    5'h04: m_emask = bus_wdata[23:0];
                    5'h08: m_rise  = bus_wdata[23:0];
                    5'h0C: m_fall  = bus_wdata[23:0];
                    5'h18: for (int i = 0; i < 8; i++) m_sel[i]   = int'(bus_wdata[4*i +: 4]);
                    5'h1C: for (int i = 0; i < 8; i++) m_sel[i+8] = int'(bus_wdata[4*i +: 4]);
                    default: ;
                endcase
            end
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            bit [23:0] a;
            bit [14:0] e;
            a = m_pend & m_imask;
            e[4:0]  = a[4:0];
            e[5]    = |a[9:5];
            e[6]    = |a[15:10];
            e[14:7] = a[23:16];
            checks++;
            if (irq_out !== e) begin
                bad++;
                $display("FAIL R8 model irq_out act=%h exp=%h at %0t", irq_out, e, $time);
            end
            checks++;
            if (evt_out !== m_evt) begin
                bad++;
                $display("FAIL R9 model evt_out act=%h exp=%h at %0t", evt_out, m_evt, $time);
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [4:0] a, logic [31:0] d);
        @(negedge clk);
        bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1;
        bus_en = 0; bus_we = 0; bus_wdata = '0;
    endtask

    task automatic rd(logic [4:0] a, logic [31:0] exp, string tag);
        @(negedge clk);
        bus_en = 1; bus_we = 0; bus_addr = a;
        #1;
        check(tag, bus_rdata, exp);
        bus_en = 0;
    endtask

    task automatic finish_run();
        done = 1;
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    endtask

    initial begin
        #(CLK_P * 20000);
        if (!done) begin
            checks++; bad++;
            $display("FAIL R1 watchdog act=running exp=finished");
            finish_run();
        end
    end

    // ---------------- directed sequence ----------------
    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;

        // R1 reset state
        for (int r = 0; r < 8; r++) rd(5'(r*4), 32'h0, "R1 reset register");
        check("R1 reset irq_out", 32'(irq_out), 32'h0);
        check("R1 reset evt_out", 32'(evt_out), 32'h0);

        // R2 map and width
        wr(5'h00, 32'hFFFF_FFFF);
        rd(5'h00, 32'h00FF_FFFF, "R2 imask 24 bits");
        wr(5'h00, 32'h0);
        wr(5'h0C, 32'h00A5_5A5A);
        rd(5'h0C, 32'h00A5_5A5A, "R2 falling select readback");
        wr(5'h0C, 32'h0);
        wr(5'h10, 32'h0080_0000);
        rd(5'h10, 32'h0, "R2 software trigger reads zero");
        rd(5'h14, 32'h0080_0000, "R5 software trigger sets pending");
        wr(5'h14, 32'h0);
        rd(5'h14, 32'h0080_0000, "R6 writing zero keeps pending");
        wr(5'h14, 32'h0080_0000);
        rd(5'h14, 32'h0, "R6 writing one clears pending");

        // R3 rising edge with latency, unselected line ignored
        wr(5'h08, 32'h1);
        @(negedge clk);
        port_pins[0] = 1; port_pins[1] = 1;
        rd(5'h14, 32'h0, "R3 not yet pending after one edge");
        rd(5'h14, 32'h1, "R3 pending after second edge, line 1 ignored");
        wr(5'h14, 32'h1);

        // R4 falling only and both edges
        wr(5'h0C, 32'h4);
        wr(5'h08, 32'h9);
        wr(5'h0C, 32'hC);
        @(negedge clk); port_pins[2] = 1;
        repeat (2) @(posedge clk);
        rd(5'h14, 32'h0, "R4 rising ignored on falling-only line");
        @(negedge clk); port_pins[2] = 0;
        repeat (2) @(posedge clk);
        rd(5'h14, 32'h4, "R4 falling edge sets pending");
        wr(5'h14, 32'h4);
        @(negedge clk); port_pins[3] = 1;
        repeat (2) @(posedge clk);
        rd(5'h14, 32'h8, "R4 both: rising sets");
        wr(5'h14, 32'h8);
        @(negedge clk); port_pins[3] = 0;
        repeat (2) @(posedge clk);
        rd(5'h14, 32'h8, "R4 both: falling sets");
        wr(5'h14, 32'hFF_FFFF);

        // R7 set wins over clear (line 0, rising armed, pend already set)
        wr(5'h10, 32'h1);
        @(negedge clk); port_pins[0] = 0;
        repeat (2) @(posedge clk);
        @(negedge clk); port_pins[0] = 1;
        wr(5'h14, 32'h1);
        rd(5'h14, 32'h1, "R7 edge and clear in same cycle keep pending");
        wr(5'h14, 32'h1);
        rd(5'h14, 32'h0, "R7 later clear works");

        // R8 interrupt grouping and masking
        wr(5'h00, 32'h0010_1081);
        wr(5'h10, 32'h0010_3081);
        check("R8 grouped irq outputs", 32'(irq_out), 32'h0861);
        wr(5'h14, 32'h0000_1000);
        check("R8 line 13 masked keeps group low", 32'(irq_out), 32'h0821);
        wr(5'h14, 32'hFF_FFFF);
        check("R8 all cleared", 32'(irq_out), 32'h0);

        // R9 event pulse
        wr(5'h04, 32'h0001_0010);
        wr(5'h10, 32'h30);
        check("R9 event pulse masked line only", 32'(evt_out), 32'h10);
        @(posedge clk); #1;
        check("R9 pulse lasts one cycle", 32'(evt_out), 32'h0);
        wr(5'h08, 32'h0001_0000);
        @(negedge clk); int_src[0] = 1;
        @(posedge clk); @(posedge clk); #1;
        check("R9 internal line edge pulse", 32'(evt_out), 32'h0001_0000);
        @(posedge clk); #1;
        check("R9 internal pulse ends", 32'(evt_out), 32'h0);
        wr(5'h14, 32'hFF_FFFF);

        // R10 port selection
        wr(5'h18, 32'h30);
        rd(5'h18, 32'h30, "R2 source field readback");
        wr(5'h08, 32'h2);
        @(negedge clk); port_pins[3*16+1] = 1;
        repeat (2) @(posedge clk);
        rd(5'h14, 32'h2, "R10 port 3 feeds line 1");
        wr(5'h14, 32'h2);
        wr(5'h1C, 32'hC0);
        wr(5'h08, 32'h200);
        @(negedge clk);
        for (int k = 0; k < 11; k++) port_pins[k*16+9] = 1;
        repeat (2) @(posedge clk);
        rd(5'h14, 32'h0, "R10 field 12 feeds constant zero");
        wr(5'h1C, 32'hA0);
        repeat (2) @(posedge clk);
        rd(5'h14, 32'h200, "R10 field 10 routes port 10");

        repeat (3) @(posedge clk);
        finish_run();
    end

endmodule